// File: doc/BRIEF.md
# Byte-Bus GPIO Port with Edge Interrupts

This block is one general-purpose I/O port with eight pins by default. It sits on a byte-wide peripheral bus. For every pin it holds an output value and a direction bit that go straight to the pad. It also holds a pull-resistor enable, two function-select bits, an interrupt edge choice, an interrupt enable and a sticky interrupt flag. The pad inputs pass through a two-flop synchronizer. The synchronized level can be read back on the bus, and it is watched for the chosen edge on each pin.

A detected edge sets that pin's flag, and the flag stays set until software clears it. A single registered interrupt request is raised while any pin has its flag and its enable set and its primary select clear. For each pin the block also reports a two-bit function code, so the pad multiplexing knows whether the pin is plain I/O or belongs to a peripheral. A synchronous power-up clear input returns the control set to zero without a full reset.

Top module: `gpio_edge_port`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every register reads as zero, and `pad_out`, `pad_oe`, `pull_en`, `pin_func` and `irq` are all zero.
- R2: A bus write (`bus_en` and `bus_wr` both high at a rising clock edge) to one of these offsets stores the data, and reads from the same offset return it: 0x21 output value, 0x22 direction, 0x23 flags, 0x24 edge choice, 0x25 interrupt enable, 0x26 primary select, 0x27 pull enable, 0x41 secondary select. Reads are combinational. A read of any other offset returns 0. A write to offset 0x20 has no effect.
- R3: `pad_out` equals the stored output value and `pad_oe` equals the stored direction bits, where 1 means the pin is driven. `pull_en` equals the stored pull-enable bits. Each follows a write from the next clock edge.
- R4: A read of offset 0x20 returns the pad levels as they were two rising edges earlier, taken through a two-flop synchronizer.
- R5: With edge-choice bit 0, a low-to-high change of the synchronized level sets that pin's flag. With edge-choice bit 1, a high-to-low change sets it. The flag is set at the third rising edge after the pad changes.
- R6: Flags are sticky. A flag write stores the written value, so writing 0 clears a flag. If an edge is detected on a pin in the same cycle as a flag write, that pin's flag ends up set.
- R7: Writing the edge-choice register never sets a flag by itself. Only a change in the synchronized input can set a flag.
- R8: `irq` is a register that holds the OR, over all pins, of (flag AND enable AND NOT primary select), taken from the previous cycle. It rises one clock after a flag sets.
- R9: `pin_func[2i+1:2i]` is {secondary select, primary select} of pin i. The codes are 00 plain I/O, 01 primary peripheral, 10 reserved, 11 secondary peripheral.
- R10: When `puc` is high at a rising edge, these are cleared: output value, direction, flags, enable, primary select, secondary select, pull enable and `irq`. This holds even if an edge is detected in that cycle. The edge-choice register and the synchronizer keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| puc | input | 1 | Synchronous power-up clear of the control set |
| bus_en | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, valid when bus_en is high |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Combinational read data |
| pad_in | input | PINS | Asynchronous pad levels |
| pad_out | output | PINS | Value driven on each pad |
| pad_oe | output | PINS | Pad output enable per pin |
| pull_en | output | PINS | Pull-resistor enable per pin |
| pin_func | output | 2*PINS | Function code per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Rising and falling pad changes are applied to pins whose edge choice is both 0 and 1. This separates pins that must flag from pins that must stay quiet. It also pins down the three-edge latency, because the model's flag timing must match on every clock.

Pulses shorter than the synchronizer delay and pads held steady while the edge choice is rewritten test that flags follow only real changes in the synchronized level. A flag clear timed onto the same cycle as a detected edge tests that the edge takes priority.

Interrupt enables combined with primary and secondary select patterns separate the masking term from a plain enable. Long random runs that mix writes, reads of every offset including unmapped ones, and power-up clears catch state that survives a clear when it should not.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 8;
    typedef logic [ADDR_W-1:0] addr_t;

    // Offsets decoded by software
    localparam addr_t A_PIN_IN = 8'h20;
    localparam addr_t A_DRIVE  = 8'h21;
    localparam addr_t A_DIR    = 8'h22;
    localparam addr_t A_FLAG   = 8'h23;
    localparam addr_t A_FALL   = 8'h24;
    localparam addr_t A_IEN    = 8'h25;
    localparam addr_t A_FSEL   = 8'h26;
    localparam addr_t A_PULL   = 8'h27;
    localparam addr_t A_FSEL2  = 8'h41;

    typedef enum logic [1:0] {
        FN_GPIO      = 2'b00,
        FN_PRIMARY   = 2'b01,
        FN_RESERVED  = 2'b10,
        FN_SECONDARY = 2'b11
    } pin_fn_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] fall_sel,
    output logic [W-1:0] hit
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise_w, fall_w;
        assign rise_w = level[i] & ~prev_q[i];
        assign fall_w = ~level[i] & prev_q[i];
        assign hit[i] = fall_sel[i] ? fall_w : rise_w;
    end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                puc,
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [PINS-1:0]     bus_wdata,
    output logic [PINS-1:0]     bus_rdata,
    input  logic [PINS-1:0]     pad_in,
    output logic [PINS-1:0]     pad_out,
    output logic [PINS-1:0]     pad_oe,
    output logic [PINS-1:0]     pull_en,
    output logic [2*PINS-1:0]   pin_func,
    output logic                irq
);

    localparam int FUNC_W = $bits(pin_fn_e);

    typedef struct packed {
        logic [PINS-1:0] drive;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] flag;
        logic [PINS-1:0] fall_sel;
        logic [PINS-1:0] ien;
        logic [PINS-1:0] fsel;
        logic [PINS-1:0] fsel2;
        logic [PINS-1:0] pull;
        logic            irq;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [PINS-1:0] sync_now;
    logic [PINS-1:0] edge_hit;
    logic [PINS-1:0] flag_now, ien_now, fsel_now;
    logic            wr_go;

    gpio_sync #(.W(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_now)
    );

    gpio_edge_det #(.W(PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (sync_now),
        .fall_sel (st_q.fall_sel),
        .hit      (edge_hit)
    );

    assign wr_go = bus_en & bus_wr;

    always_comb begin
        st_d = st_q;
        if (wr_go) begin
            case (bus_addr)
                A_DRIVE: st_d.drive    = bus_wdata;
                A_DIR:   st_d.dir      = bus_wdata;
                A_FLAG:  st_d.flag     = bus_wdata;
                A_FALL:  st_d.fall_sel = bus_wdata;
                A_IEN:   st_d.ien      = bus_wdata;
                A_FSEL:  st_d.fsel     = bus_wdata;
                A_PULL:  st_d.pull     = bus_wdata;
                A_FSEL2: st_d.fsel2    = bus_wdata;
                default: ;
            endcase
        end
        st_d.flag = st_d.flag | edge_hit;
        st_d.irq  = |(st_q.flag & st_q.ien & ~st_q.fsel);
        if (puc) begin
            st_d.drive = '0;
            st_d.dir   = '0;
            st_d.flag  = '0;
            st_d.ien   = '0;
            st_d.fsel  = '0;
            st_d.fsel2 = '0;
            st_d.pull  = '0;
            st_d.irq   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en) begin
            case (bus_addr)
                A_PIN_IN: bus_rdata = sync_now;
                A_DRIVE:  bus_rdata = st_q.drive;
                A_DIR:    bus_rdata = st_q.dir;
                A_FLAG:   bus_rdata = st_q.flag;
                A_FALL:   bus_rdata = st_q.fall_sel;
                A_IEN:    bus_rdata = st_q.ien;
                A_FSEL:   bus_rdata = st_q.fsel;
                A_PULL:   bus_rdata = st_q.pull;
                A_FSEL2:  bus_rdata = st_q.fsel2;
                default:  bus_rdata = '0;
            endcase
        end
    end

    for (genvar i = 0; i < PINS; i++) begin : g_route
        pin_fn_e code_w;
        assign code_w = pin_fn_e'({st_q.fsel2[i], st_q.fsel[i]});
        assign pin_func[FUNC_W*i +: FUNC_W] = code_w;
    end

    assign pad_out  = st_q.drive;
    assign pad_oe   = st_q.dir;
    assign pull_en  = st_q.pull;
    assign irq      = st_q.irq;
    assign flag_now = st_q.flag;
    assign ien_now  = st_q.ien;
    assign fsel_now = st_q.fsel;

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              puc,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   flag_now,
    input logic [PINS-1:0]   ien_now,
    input logic [PINS-1:0]   fsel_now,
    input logic [PINS-1:0]   sync_now,
    input logic [PINS-1:0]   edge_hit,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pull_en,
    input logic [2*PINS-1:0] pin_func,
    input logic              irq
);

    logic flag_wr;
    assign flag_wr = bus_en & bus_wr & (bus_addr == A_FLAG);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(flag_now & ien_now & ~fsel_now)));

    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(flag_now & ien_now & ~fsel_now)) && !puc) |=> irq);

    assert_edge_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|edge_hit) && !puc) |=> ((flag_now & $past(edge_hit)) == $past(edge_hit)));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!puc && !flag_wr) |=> ((flag_now & $past(flag_now)) == $past(flag_now)));

    assert_hit_needs_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |-> (sync_now != $past(sync_now)));

    assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        puc |=> (flag_now == '0 && pad_oe == '0 && pull_en == '0 &&
                 pin_func == '0 && !irq));

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.PINS(PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .puc      (puc),
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .flag_now (flag_now),
    .ien_now  (ien_now),
    .fsel_now (fsel_now),
    .sync_now (sync_now),
    .edge_hit (edge_hit),
    .pad_oe   (pad_oe),
    .pull_en  (pull_en),
    .pin_func (pin_func),
    .irq      (irq)
);

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;

    localparam int P = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         puc = 1'b0;
    logic         bus_en = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = 8'h00;
    logic [P-1:0] bus_wdata = '0;
    logic [P-1:0] bus_rdata;
    logic [P-1:0] pad_in = '0;
    logic [P-1:0] pad_out, pad_oe, pull_en;
    logic [2*P-1:0] pin_func;
    logic         irq;

    always #4 clk = ~clk;

    gpio_edge_port #(.PINS(P)) dut (
        .clk(clk), .rst_n(rst_n), .puc(puc),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pull_en(pull_en), .pin_func(pin_func), .irq(irq)
    );

    // behavioural reference state
    logic [P-1:0] m_out = '0, m_dir = '0, m_flg = '0, m_fall = '0, m_ie = '0;
    logic [P-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_sel = '0, m_sel2 = '0, m_pull = '0;
    logic         m_irq = 1'b0;
    bit           started = 0;
    int           vectors = 0;
    int           errors = 0;
    bit           done = 0;
    string        phase = "R1";

    always @(posedge clk) begin
        logic [P-1:0] hits;
        logic         nirq;
        started = 1;
        if (!rst_n) begin
            m_out = '0; m_dir = '0; m_flg = '0; m_fall = '0; m_ie = '0;
            m_sel = '0; m_sel2 = '0; m_pull = '0; m_irq = 0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            hits = '0;
            for (int i = 0; i < P; i++) begin
                if (m_fall[i] == 0 && m_prev[i] == 0 && m_s2[i] == 1) hits[i] = 1;
                if (m_fall[i] == 1 && m_prev[i] == 1 && m_s2[i] == 0) hits[i] = 1;
            end
            nirq = (m_flg & m_ie & ~m_sel) != 0;
            if (bus_en && bus_wr) begin
                if (bus_addr == 8'h21) m_out  = bus_wdata;
                if (bus_addr == 8'h22) m_dir  = bus_wdata;
                if (bus_addr == 8'h23) m_flg  = bus_wdata;
                if (bus_addr == 8'h24) m_fall = bus_wdata;
                if (bus_addr == 8'h25) m_ie   = bus_wdata;
                if (bus_addr == 8'h26) m_sel  = bus_wdata;
                if (bus_addr == 8'h27) m_pull = bus_wdata;
                if (bus_addr == 8'h41) m_sel2 = bus_wdata;
            end
            m_flg = m_flg | hits;
            m_irq = nirq;
            if (puc) begin
                m_out = '0; m_dir = '0; m_flg = '0; m_ie = '0;
                m_sel = '0; m_sel2 = '0; m_pull = '0; m_irq = 0;
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
        end
    end

    function automatic logic [P-1:0] exp_read();
        if (!bus_en) return '0;
        case (bus_addr)
            8'h20: return m_s2;
            8'h21: return m_out;
            8'h22: return m_dir;
            8'h23: return m_flg;
            8'h24: return m_fall;
            8'h25: return m_ie;
            8'h26: return m_sel;
            8'h27: return m_pull;
            8'h41: return m_sel2;
            default: return '0;
        endcase
    endfunction

    function automatic logic [2*P-1:0] exp_func();
        logic [2*P-1:0] f;
        for (int i = 0; i < P; i++) f[2*i +: 2] = {m_sel2[i], m_sel[i]};
        return f;
    endfunction

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %h expected %h", phase, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            cmp("pad_out R3", 32'(pad_out), 32'(m_out));
            cmp("pad_oe R3", 32'(pad_oe), 32'(m_dir));
            cmp("pull_en R3", 32'(pull_en), 32'(m_pull));
            cmp("pin_func R9", 32'(pin_func), 32'(exp_func()));
            cmp("irq R8", 32'(irq), 32'(m_irq));
            cmp("bus_rdata R2/R4", 32'(bus_rdata), 32'(exp_read()));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [P-1:0] d);
        step();
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        step();
        bus_en = 1; bus_wr = 0; bus_addr = a;
        step();
    endtask

    task automatic read_all();
        rd(8'h20); rd(8'h21); rd(8'h22); rd(8'h23); rd(8'h24);
        rd(8'h25); rd(8'h26); rd(8'h27); rd(8'h41); rd(8'h30);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] addrs [10];
        addrs = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'h41, 8'h30};
        // R1: reset state
        phase = "R1";
        bus_en = 1; bus_addr = 8'h23;
        repeat (4) step();
        rst_n = 1;
        read_all();

        // R2 R3 R9: write and read back every register
        phase = "R2";
        wr(8'h21, 8'hA5); wr(8'h22, 8'h3C); wr(8'h27, 8'h0F);
        wr(8'h26, 8'h55); wr(8'h41, 8'h33); wr(8'h25, 8'hF0);
        wr(8'h20, 8'hFF); wr(8'h30, 8'hFF);
        read_all();
        phase = "R9";
        wr(8'h26, 8'hC3); wr(8'h41, 8'hA5); read_all();
        wr(8'h26, 8'h00); wr(8'h41, 8'h00);

        // R4 R5: rising on low half, falling on high half
        phase = "R5";
        wr(8'h24, 8'hF0); wr(8'h23, 8'h00);
        rd(8'h20);
        step(); pad_in = 8'h0F;
        repeat (5) step();
        rd(8'h23);
        step(); pad_in = 8'hF0;
        repeat (5) step();
        read_all();

        // R8: enable and mask by primary select
        phase = "R8";
        wr(8'h25, 8'hFF); repeat (3) step();
        wr(8'h26, 8'hFF); repeat (3) step();
        wr(8'h41, 8'hFF); repeat (3) step();
        wr(8'h26, 8'h00); repeat (3) step();
        wr(8'h23, 8'h00); repeat (3) step();

        // R6: clear lands on the same edge as a detection
        phase = "R6";
        wr(8'h24, 8'h00); step(); pad_in = 8'h00; repeat (5) step();
        wr(8'h23, 8'h00);
        step(); pad_in = 8'hFF;
        step();
        wr(8'h23, 8'h00);
        rd(8'h23); repeat (3) step();

        // R7: edge choice rewrites with steady pads
        phase = "R7";
        wr(8'h23, 8'h00);
        wr(8'h24, 8'hFF); wr(8'h24, 8'h00); wr(8'h24, 8'h5A);
        rd(8'h23); repeat (3) step();
        // pulse shorter than the synchronizer sees as one sample
        step(); pad_in = 8'h00; step(); pad_in = 8'hFF; repeat (5) step(); rd(8'h23);

        // R10: power-up clear
        phase = "R10";
        wr(8'h21, 8'hFF); wr(8'h22, 8'hFF); wr(8'h27, 8'hFF); wr(8'h25, 8'hFF);
        wr(8'h23, 8'hFF); wr(8'h26, 8'h0F); wr(8'h41, 8'hF0); wr(8'h24, 8'h3C);
        step(); puc = 1; pad_in = 8'h00; step(); puc = 0;
        read_all();

        // random mix
        phase = "R2/R5/R6/R8/R10";
        for (int n = 0; n < 6000; n++) begin
            step();
            bus_en    = ($urandom_range(0, 7) != 0);
            bus_wr    = ($urandom_range(0, 2) == 0);
            bus_addr  = addrs[$urandom_range(0, 9)];
            bus_wdata = P'($urandom);
            puc       = ($urandom_range(0, 150) == 0);
            if ($urandom_range(0, 3) == 0) pad_in = pad_in ^ P'($urandom);
        end
        step(); bus_en = 0; bus_wr = 0; puc = 0;
        repeat (4) step();
        finish_run();
    end

endmodule